// File: doc/BRIEF.md
# Receive Self-Test Checker and Ready Strobe

This block sits after the byte decoder on the receive side of a serial link. Each cycle in which a decoded character is offered, it receives three items: the byte, a flag marking it as a control character, and a flag marking a code-rule violation. From these it drives two registered status outputs: an active-low ready strobe and a violation indicator.

In normal mode the ready strobe pulses low once for each received character that is not the idle fill comma. The violation output reports the violation flag of the most recent character. In self-test mode the block first waits for a zero data character, which serves as the loop marker. It then compares every following character against a local pseudo-random generator that runs in step with the transmitter's generator. Any mismatch is reported on the violation output, and the ready strobe goes high only for the last character of each 511-character loop.

The character input is a valid-only stream, so there is no back-pressure. The block accepts a character on every cycle in which `in_valid` is high and has no way to stall the decoder. Cycles in which `in_valid` is low carry no character.

Top module: `bist_rx_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it, `rdy_n` is 1 and `viol_out` is 0.
- R2: In normal mode (`bist_n`=1), a valid character that is not fill drives `rdy_n` low during the cycle after it is taken.
- R3: In normal mode, the fill character gives no ready pulse: `rdy_n` stays 1. The fill character is `in_special`=1, `in_viol`=0, `in_data`=0xBC.
- R4: In normal mode, `viol_out` equals `in_viol` of the last valid character, from the cycle after that character onward.
- R5: In self-test mode (`bist_n`=0), until a marker has been seen, every character gives `rdy_n`=1 and `viol_out`=0.
- R6: The marker is `in_data`=0, `in_special`=0, `in_viol`=0. After the marker, the expected sequence comes from a 9-bit state s that starts at the successor of all-ones and advances by s' = {s[7:0], s[8]^s[4]} once per valid character. The expected character is data = ~s[7:0] and special = ~s[8]. The state s = 0x0FF instead expects a violation symbol.
- R7: While checking, `viol_out` is 0 after a character that matches the expected character (data, special flag, and no violation) and 1 after one that does not.
- R8: When the expected character is the violation symbol, a received character with `in_viol`=1 matches and one with `in_viol`=0 mismatches.
- R9: While checking, `rdy_n` is 1 after the last character of a loop (the expected violation symbol) and 0 after every other character, including the marker that starts checking.
- R10: Leaving self-test mode sends the checker back to waiting for a marker, so a later self-test needs a new marker.
- R11: On a cycle without a valid character, `rdy_n` returns to 1 in normal mode, and both outputs hold their value in self-test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bist_n | input | 1 | Self-test enable, active low |
| in_valid | input | 1 | A decoded character is present this cycle |
| in_data | input | DATA_W | Decoded byte |
| in_special | input | 1 | Character is a control character |
| in_viol | input | 1 | Character broke a code rule |
| rdy_n | output | 1 | Ready strobe, active low |
| viol_out | output | 1 | Violation / self-test mismatch indicator |

## Verification
The bench uses the default parameters: an 8-bit byte, a generator tap at bit 4, and a fill code of 0xBC. With these values the 511-character loop is short enough to be walked end to end twice. This brings two events within reach: the wrap from the violation symbol back to the marker, and a second expected violation that is deliberately received as plain data. A table of normal-mode vectors covers the fill, the near-fill characters and idle cycles. Directed steps then cover waiting before the marker, an injected data error, an idle gap during checking, and re-entry after self-test is left.

// File: rtl/bist_rx_pkg.sv
package bist_rx_pkg;
  typedef enum logic {
    CHK_WAIT = 1'b0,
    CHK_RUN  = 1'b1
  } chk_state_e;

  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_TAP    = 5;
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int unsigned W   = 9,
  parameter int unsigned TAP = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] ALL_ONES = '1;

  function automatic logic [W-1:0] advance(input logic [W-1:0] s);
    return {s[W-2:0], s[W-1] ^ s[TAP-1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= ALL_ONES;
    else if (load) state <= advance(ALL_ONES);
    else if (step) state <= advance(state);
  end

  AST_LFSR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (state != $past(state))); // R6

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state != '0)); // R6
endmodule

// File: rtl/bist_expect.sv
module bist_expect #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W:0]   state,
  output logic [DATA_W-1:0] exp_data,
  output logic              exp_special,
  output logic              exp_violation,
  output logic              loop_last
);
  localparam logic [DATA_W:0] VIOL_STATE = {1'b0, {DATA_W{1'b1}}};

  always_comb begin
    exp_data      = ~state[DATA_W-1:0];
    exp_special   = ~state[DATA_W];
    exp_violation = (state == VIOL_STATE);
    // the state before all-ones (the marker) is always VIOL_STATE
    loop_last     = exp_violation;
  end
endmodule

// File: rtl/bist_compare.sv
module bist_compare #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_special,
  input  logic              in_viol,
  input  logic [DATA_W-1:0] exp_data,
  input  logic              exp_special,
  input  logic              exp_violation,
  output logic              match
);
  always_comb begin
    if (exp_violation) match = in_viol;
    else match = !in_viol && (in_special == exp_special) && (in_data == exp_data);
  end
endmodule

// File: rtl/bist_rx_monitor.sv
module bist_rx_monitor
  import bist_rx_pkg::*;
#(
  parameter int unsigned       DATA_W    = DEF_DATA_W,
  parameter int unsigned       TAP       = DEF_TAP,
  parameter logic [DATA_W-1:0] FILL_CODE = 8'hBC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_special,
  input  logic              in_viol,
  output logic              rdy_n,
  output logic              viol_out
);
  localparam int unsigned LFSR_W = DATA_W + 1;

  chk_state_e          st_q;
  logic [LFSR_W-1:0]   lfsr_state;
  logic [DATA_W-1:0]   exp_data;
  logic                exp_special;
  logic                exp_violation;
  logic                loop_last;
  logic                match;
  logic                is_fill;
  logic                is_marker;
  logic                lfsr_load;
  logic                lfsr_step;

  always_comb begin
    is_fill   = in_special && !in_viol && (in_data == FILL_CODE);
    is_marker = !in_special && !in_viol && (in_data == '0);
    lfsr_load = !bist_n && in_valid && (st_q == CHK_WAIT) && is_marker;
    lfsr_step = !bist_n && in_valid && (st_q == CHK_RUN);
  end

  bist_lfsr #(.W(LFSR_W), .TAP(TAP)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (lfsr_load),
    .step  (lfsr_step),
    .state (lfsr_state)
  );

  bist_expect #(.DATA_W(DATA_W)) u_expect (
    .state         (lfsr_state),
    .exp_data      (exp_data),
    .exp_special   (exp_special),
    .exp_violation (exp_violation),
    .loop_last     (loop_last)
  );

  bist_compare #(.DATA_W(DATA_W)) u_compare (
    .in_data       (in_data),
    .in_special    (in_special),
    .in_viol       (in_viol),
    .exp_data      (exp_data),
    .exp_special   (exp_special),
    .exp_violation (exp_violation),
    .match         (match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= CHK_WAIT;
      rdy_n    <= 1'b1;
      viol_out <= 1'b0;
    end else if (bist_n) begin
      st_q  <= CHK_WAIT;
      rdy_n <= !(in_valid && !is_fill);
      if (in_valid) viol_out <= in_viol;
    end else if (in_valid) begin
      if (st_q == CHK_WAIT) begin
        viol_out <= 1'b0;
        if (is_marker) begin
          st_q  <= CHK_RUN;
          rdy_n <= 1'b0;
        end else begin
          rdy_n <= 1'b1;
        end
      end else begin
        rdy_n    <= loop_last;
        viol_out <= !match;
      end
    end
  end

  AST_FILL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_n && in_valid && in_special && !in_viol && in_data == FILL_CODE) |=> rdy_n); // R3

  AST_NORMAL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_n && in_valid && !(in_special && !in_viol && in_data == FILL_CODE)) |=> !rdy_n); // R2

  AST_NORMAL_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_n && in_valid) |=> (viol_out == $past(in_viol))); // R4

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bist_n && in_valid && st_q == CHK_WAIT && !is_marker) |=> (rdy_n && !viol_out)); // R5

  AST_IDLE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_n && !in_valid) |=> rdy_n); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bist_n && !in_valid) |=> ($stable(rdy_n) && $stable(viol_out))); // R11

  AST_EXIT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    bist_n |=> (st_q == CHK_WAIT)); // R10
endmodule

// File: tb/bist_rx_monitor_test.sv
module bist_rx_monitor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bist_n = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_special = 1'b0;
  logic       in_viol = 1'b0;
  logic       rdy_n;
  logic       viol_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bist_rx_monitor uut (
    .clk(clk), .rst_n(rst_n), .bist_n(bist_n), .in_valid(in_valid),
    .in_data(in_data), .in_special(in_special), .in_viol(in_viol),
    .rdy_n(rdy_n), .viol_out(viol_out)
  );

  // {valid, special, viol, data[7:0], exp_rdy_n, exp_viol}
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'h12, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b0, 8'hBC, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b1, 8'h55, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
    {1'b1, 1'b1, 1'b0, 8'h7C, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'hBC, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b0, 8'hBC, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b0, 8'hBC, 1'b1, 1'b0}
  };

  function automatic logic [8:0] nxt(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic v, input logic sp, input logic vi, input logic [7:0] d,
                      input logic erdy, input logic eviol, input string tag);
    @(negedge clk);
    in_valid = v; in_special = sp; in_viol = vi; in_data = d;
    @(posedge clk);
    #2;
    chk({tag, " rdy_n"}, rdy_n, erdy);
    chk({tag, " viol_out"}, viol_out, eviol);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] s;
    int viol_seen;
    logic prev_rdy, prev_viol;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset rdy_n", rdy_n, 1'b1);
    chk("R1 reset viol_out", viol_out, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 after reset rdy_n", rdy_n, 1'b1);
    chk("R1 after reset viol_out", viol_out, 1'b0);

    // normal mode table: R2 ready pulse, R3 fill, R4 violation, R11 idle
    for (int i = 0; i < NV; i++)
      send(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9:2], VEC[i][1], VEC[i][0],
           $sformatf("R2 R3 R4 R11 vec%0d", i));

    // self-test waiting: R5
    @(negedge clk) bist_n = 1'b0;
    send(1'b1, 1'b0, 1'b0, 8'h33, 1'b1, 1'b0, "R5 wait data");
    send(1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, "R5 wait violation");
    send(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R5 wait K0");
    // marker: R6, R9
    send(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R6 R9 marker");

    s = nxt(9'h1FF);
    viol_seen = 0;
    for (int i = 0; i < 1022; i++) begin
      logic [7:0] d;
      logic sp, vi, er, ev;
      d = ~s[7:0]; sp = ~s[8]; vi = 1'b0; er = 1'b0; ev = 1'b0;
      if (s == 9'h0FF) begin
        viol_seen++;
        er = 1'b1;
        if (viol_seen == 1) vi = 1'b1;         // R8 matched violation
        else ev = 1'b1;                         // R8 missed violation
        send(1'b1, sp, vi, d, er, ev, "R8 R9 loop end");
      end else if (i == 40) begin
        send(1'b1, sp, 1'b0, d ^ 8'h01, 1'b0, 1'b1, "R7 corrupted byte");
      end else if (i == 41) begin
        send(1'b1, sp, 1'b1, d, 1'b0, 1'b1, "R7 unexpected violation");
      end else begin
        send(1'b1, sp, vi, d, er, ev, "R7 R9 match");
      end
      if (i == 100) begin
        prev_rdy = rdy_n; prev_viol = viol_out;
        send(1'b0, 1'b1, 1'b1, 8'hAA, prev_rdy, prev_viol, "R11 idle hold");
      end
      s = nxt(s);
    end

    // leave and re-enter self-test: R10
    @(negedge clk) begin bist_n = 1'b1; in_valid = 1'b0; end
    @(posedge clk); #2;
    chk("R10 exit rdy_n", rdy_n, 1'b1);
    @(negedge clk) bist_n = 1'b0;
    send(1'b1, ~s[8], 1'b0, ~s[7:0], 1'b1, 1'b0, "R10 re-entry waits");
    send(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R10 new marker");
    s = nxt(9'h1FF);
    send(1'b1, ~s[8], 1'b0, ~s[7:0], 1'b0, 1'b0, "R10 R7 first after marker");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule